// File: doc/BRIEF.md
# HDMI Transmitter Interrupt Collector

This block collects eight interrupt events from an HDMI transmitter wrapper. Each event sets a sticky status bit, and the block drives one interrupt request line towards the processor. The events are hot-plug rise and fall, receiver-sense rise and fall, a bus timeout, a random-number error, a nonce-refresh edge, and a rising edge of the embedded controller core's level interrupt.

Software uses a simple register-bus slave port with three registers:
- **Enable mask.** A 1 in a bit lets that source reach the request line.
- **Status.** It reads the sticky bits. Writing a 1 forces a bit set, which is useful for testing the handler path. Bit 31 shows the live core interrupt level.
- **Clear.** Writing a 1 removes a sticky bit.

Sticky bits capture events whether or not they are enabled. Reads are combinational from the address. Writes take effect on the clock edge at which `bus_wr_i` is high.

Top module: `tx_irq_collect`

## Requirements
- R1: After reset the mask register, every status bit and `irq_o` are 0.
- R2: Register offset 0 is the mask. A write stores `bus_wdata_i[7:0]`, and a read returns it in bits [7:0] with the other bits 0. Mask bit i at 1 enables source i.
- R3: Status bit 0 sets on a rising edge of `core_irq_i`. A core line that stays high after bit 0 is cleared does not set it again.
- R4: A one-cycle high on `evt_i[j]` sets status bit j+1. The bit order is:
  - 1: hot-plug rise
  - 2: hot-plug fall
  - 3: nonce refresh
  - 4: random-number error
  - 5: bus timeout
  - 6: receiver-sense rise
  - 7: receiver-sense fall
- R5: Register offset 1 is the status register.
  - Writing 1 to bit i of [7:0] sets status bit i.
  - A read returns the sticky bits in [7:0] and the present `core_irq_i` level in bit 31; other bits read 0.
- R6: Register offset 2 is the clear register. Writing 1 to bit i of [7:0] clears status bit i, and the register reads as 0. Offset 3 reads as 0.
- R7: Writing 0 to any status or clear bit leaves that status bit unchanged.
- R8: If a set (hardware event or software force) and a clear reach the same bit in one cycle, the bit ends up set.
- R9: `irq_o` is registered. After each edge it equals the OR, over all bits, of status AND mask as they stood before that edge.
- R10: Status bits latch while masked. Enabling a pending source raises `irq_o` one cycle after the mask write takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| evt_i | input | 7 | Event pulses for status bits 1 to 7 |
| core_irq_i | input | 1 | Embedded core interrupt level |
| irq_o | output | 1 | Interrupt request |

## Verification
The in-RTL assertions check the following on every cycle:
- Each set bit stays set unless a clear reaches it.
- A clear bit stays clear unless a set reaches it.
- A hardware event or a core rising edge always lands in status.
- `irq_o` follows the masked status one cycle later.

Only the bench's scenarios show the register-level behaviours:
- Decode at each offset and the live bit 31.
- A held core line not re-firing after a clear.
- Set winning over clear.
- A masked pending source asserting the request once it is enabled.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   typedef enum logic [1:0] {
      SEL_MASK = 2'd0,
      SEL_STAT = 2'd1,
      SEL_CLR  = 2'd2,
      SEL_NONE = 2'd3
   } irqc_sel_e;
endpackage

// File: rtl/irqc_edge.sv
module irqc_edge (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic lvl_i,
   output logic rise_o
);
   logic lvl_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lvl_q <= 1'b0;
      else         lvl_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/irqc_sticky.sv
module irqc_sticky #(
   parameter int unsigned NUM_SRC = 8
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [NUM_SRC-1:0] set_i,
   input  logic [NUM_SRC-1:0] clr_i,
   output logic [NUM_SRC-1:0] stat_o
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)       bit_q <= 1'b0;
         else if (set_i[i]) bit_q <= 1'b1;   // set wins over clear
         else if (clr_i[i]) bit_q <= 1'b0;
      end
      assign stat_o[i] = bit_q;

      // R7
      sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (bit_q && !clr_i[i]) |=> bit_q);
      // R8
      set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         set_i[i] |=> bit_q);
      // R7
      no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!bit_q && !set_i[i]) |=> !bit_q);
   end
endmodule

// File: rtl/irqc_regif.sv
module irqc_regif
   import irqc_pkg::*;
#(
   parameter int unsigned NUM_SRC = 8,
   parameter int unsigned ADDR_W  = 2,
   parameter int unsigned DATA_W  = 32
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               wr_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [DATA_W-1:0]  wdata_i,
   input  logic [NUM_SRC-1:0] stat_i,
   input  logic               live_i,
   output logic [NUM_SRC-1:0] mask_o,
   output logic [NUM_SRC-1:0] sw_set_o,
   output logic [NUM_SRC-1:0] sw_clr_o,
   output logic [DATA_W-1:0]  rdata_o
);
   localparam int unsigned LIVE_BIT = DATA_W - 1;

   irqc_sel_e sel;
   logic [NUM_SRC-1:0] mask_q;
   logic unused_wdata;

   assign unused_wdata = ^wdata_i[DATA_W-1:NUM_SRC];

   always_comb begin
      if (addr_i == ADDR_W'(SEL_MASK))      sel = SEL_MASK;
      else if (addr_i == ADDR_W'(SEL_STAT)) sel = SEL_STAT;
      else if (addr_i == ADDR_W'(SEL_CLR))  sel = SEL_CLR;
      else                                  sel = SEL_NONE;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      mask_q <= '0;
      else if (wr_i && sel == SEL_MASK) mask_q <= wdata_i[NUM_SRC-1:0];
   end

   assign sw_set_o = (wr_i && sel == SEL_STAT) ? wdata_i[NUM_SRC-1:0] : '0;
   assign sw_clr_o = (wr_i && sel == SEL_CLR)  ? wdata_i[NUM_SRC-1:0] : '0;
   assign mask_o   = mask_q;

   always_comb begin
      rdata_o = '0;
      case (sel)
         SEL_MASK: rdata_o[NUM_SRC-1:0] = mask_q;
         SEL_STAT: begin
            rdata_o[NUM_SRC-1:0] = stat_i;
            rdata_o[LIVE_BIT]    = live_i;
         end
         default:  rdata_o = '0;
      endcase
   end

   // R2
   mask_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_i && sel == SEL_MASK) |=> $stable(mask_q));
endmodule

// File: rtl/tx_irq_collect.sv
module tx_irq_collect #(
   parameter int unsigned NUM_SRC = 8,
   parameter int unsigned ADDR_W  = 2,
   parameter int unsigned DATA_W  = 32
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               bus_wr_i,
   input  logic [ADDR_W-1:0]  bus_addr_i,
   input  logic [DATA_W-1:0]  bus_wdata_i,
   output logic [DATA_W-1:0]  bus_rdata_o,
   input  logic [NUM_SRC-2:0] evt_i,
   input  logic               core_irq_i,
   output logic               irq_o
);
   if (NUM_SRC < 2 || NUM_SRC >= DATA_W) begin : g_bad_src
      $error("NUM_SRC must lie in 2..DATA_W-1");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must be at least 2");
   end

   logic               core_rise;
   logic [NUM_SRC-1:0] mask, sw_set, sw_clr, stat, set_all;
   logic               irq_q;

   irqc_edge u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (core_irq_i),
      .rise_o (core_rise)
   );

   assign set_all = sw_set | {evt_i, core_rise};

   irqc_sticky #(.NUM_SRC(NUM_SRC)) u_sticky (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_all),
      .clr_i  (sw_clr),
      .stat_o (stat)
   );

   irqc_regif #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (bus_wr_i),
      .addr_i   (bus_addr_i),
      .wdata_i  (bus_wdata_i),
      .stat_i   (stat),
      .live_i   (core_irq_i),
      .mask_o   (mask),
      .sw_set_o (sw_set),
      .sw_clr_o (sw_clr),
      .rdata_o  (bus_rdata_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q <= 1'b0;
      else         irq_q <= |(stat & mask);
   end
   assign irq_o = irq_q;

   // R9
   irq_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|(stat & mask)) |=> irq_o);
   // R9
   irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(|(stat & mask)) |=> !irq_o);
   // R3
   core_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(core_irq_i) |=> stat[0]);
   // R4
   evt_land_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|evt_i) |=> ((stat[NUM_SRC-1:1] & $past(evt_i)) == $past(evt_i)));
endmodule

// File: tb/test_tx_irq_collect.sv
module test_tx_irq_collect;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [6:0]  evt = '0;
   logic        core = 1'b0;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;

   logic [7:0] mask_m = '0;
   logic [7:0] stat_m = '0;
   logic       irq_m = 1'b0;
   logic       core_prev = 1'b0;

   always #5 clk = ~clk;

   tx_irq_collect i_tx_irq_collect (
      .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata), .evt_i(evt),
      .core_irq_i(core), .irq_o(irq)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] model_read(input logic [1:0] a, input logic c);
      case (a)
         2'd0:    return {24'd0, mask_m};
         2'd1:    return {c, 23'd0, stat_m};
         default: return 32'd0;
      endcase
   endfunction

   function automatic string addr_req(input logic [1:0] a);
      case (a)
         2'd0:    return "R2";
         2'd1:    return "R5";
         default: return "R6";
      endcase
   endfunction

   // One cycle: drive at negedge, check read, advance model, check irq.
   task automatic cyc(input logic w, input logic [1:0] a, input logic [31:0] d,
                      input logic [6:0] e, input logic c);
      logic [31:0] exp_rd;
      logic [7:0]  set_v, clr_v;
      wr = w; addr = a; wdata = d; evt = e; core = c;
      #1;
      exp_rd = model_read(a, c);
      check(rdata === exp_rd, addr_req(a), rdata, exp_rd);
      set_v = {e, c & ~core_prev} | ((w && a == 2'd1) ? d[7:0] : 8'd0);
      clr_v = (w && a == 2'd2) ? d[7:0] : 8'd0;
      irq_m = |(stat_m & mask_m);
      stat_m = (stat_m & ~clr_v) | set_v;
      if (w && a == 2'd0) mask_m = d[7:0];
      core_prev = c;
      @(posedge clk);
      @(negedge clk);
      check(irq === irq_m, "R9", {31'd0, irq}, {31'd0, irq_m});
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd7321));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(irq === 1'b0, "R1", {31'd0, irq}, 32'd0);
      addr = 2'd0; #1;
      check(rdata === 32'd0, "R1", rdata, 32'd0);
      addr = 2'd1; #1;
      check(rdata === 32'd0, "R1", rdata, 32'd0);
      @(negedge clk);

      // R10: events latch while masked, then enabling raises irq
      cyc(1'b0, 2'd1, 0, 7'b0000011, 1'b0);     // R4: hot-plug rise/fall -> bits 1,2
      cyc(1'b0, 2'd1, 0, 7'b0, 1'b0);
      check(rdata[7:0] === 8'h06, "R4", rdata, 32'h06);
      check(irq === 1'b0, "R10", {31'd0, irq}, 32'd0);
      cyc(1'b1, 2'd0, 32'h04, 7'b0, 1'b0);      // enable bit 2
      cyc(1'b0, 2'd0, 0, 7'b0, 1'b0);
      check(irq === 1'b1, "R10", {31'd0, irq}, 32'd1);

      // R7: writing zeros has no effect
      cyc(1'b1, 2'd1, 32'h0, 7'b0, 1'b0);
      cyc(1'b1, 2'd2, 32'h0, 7'b0, 1'b0);
      cyc(1'b0, 2'd1, 0, 7'b0, 1'b0);
      check(rdata[7:0] === 8'h06, "R7", rdata, 32'h06);

      // R8: set and clear on the same bit -> stays set
      cyc(1'b1, 2'd2, 32'hFF, 7'b1000000, 1'b0); // clear all, receiver-sense fall (bit 7)
      cyc(1'b0, 2'd1, 0, 7'b0, 1'b0);
      check(rdata[7:0] === 8'h80, "R8", rdata, 32'h80);

      // R3 / R5: core rise, live bit 31, held level does not re-set
      cyc(1'b0, 2'd1, 0, 7'b0, 1'b1);
      cyc(1'b0, 2'd1, 0, 7'b0, 1'b1);
      check(rdata === 32'h8000_0081, "R3", rdata, 32'h8000_0081);
      cyc(1'b1, 2'd2, 32'h01, 7'b0, 1'b1);
      cyc(1'b0, 2'd1, 0, 7'b0, 1'b1);
      cyc(1'b0, 2'd1, 0, 7'b0, 1'b1);
      check(rdata === 32'h8000_0080, "R3", rdata, 32'h8000_0080);
      // R5: software force
      cyc(1'b1, 2'd1, 32'h18, 7'b0, 1'b0);
      cyc(1'b0, 2'd1, 0, 7'b0, 1'b0);
      check(rdata[7:0] === 8'h98, "R5", rdata, 32'h98);
      // R6: offsets 2 and 3 read zero
      cyc(1'b0, 2'd3, 0, 7'b0, 1'b0);

      // Random phase
      for (int k = 0; k < 4000; k++) begin
         logic        w;
         logic [6:0]  e;
         logic        c;
         w = ($urandom % 3) == 0;
         e = 7'($urandom & $urandom & $urandom);
         c = (($urandom % 8) == 0) ? ~core : core;
         cyc(w, 2'($urandom), $urandom, e, c);
      end

      summary();
      $finish;
   end
endmodule